// File: doc/BRIEF.md
# Soft-Decision Requantizer for a Viterbi Decoder Input

This block takes received channel soft decisions and reduces their precision to what a Viterbi decoder can use. That keeps the decoder's branch metrics inside a signed 7-bit range of −64 to +63. Each input sample is a two's complement byte with four fractional bits, so +1.0 is 0x10 and −1.0 is 0xF0. One 32-bit word carries four samples, and all four are converted in parallel.

The output resolution D depends on the code rate:
- At rate 1/2, D is 6 bits.
- At rates 1/3 and 1/4, D is 5 bits, for any constraint length from 5 to 9.

Each lane is shifted right arithmetically by D−4 places. The result is clamped to the range a D-bit signed value can hold, and then sign-extended back to a full byte. At rate 1/3 the output byte therefore has the sign copied into its top four bits, one integer bit and three fractional bits.

Words enter and leave on a valid/ready stream with one register stage. The rate selection is sampled only while the block is idle, so that every word of a frame uses the same resolution.

Top module: `requant_vit`

## Requirements
- R1: While reset is held and on the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: With rate_sel = 0 (rate 1/2, D = 6), each output lane equals its input lane shifted right arithmetically by 2, sign-extended to 8 bits. No input byte needs clamping in this mode.
- R3: With rate_sel = 1 (rate 1/3) or rate_sel = 2 (rate 1/4), D = 5, and each output lane equals its input lane shifted right arithmetically by 1, within the 5-bit range.
- R4: rate_sel = 3 is handled like rates 1/3 and 1/4 (D = 5).
- R5: In 5-bit mode, a lane whose shifted value is above +15 outputs 0x0F, and a lane whose shifted value is below −16 outputs 0xF0. A lane that is exactly at either limit passes unchanged.
- R6: Lane k occupies bits 8k+7 down to 8k of both in_data and out_data, with lane 0 in the least significant byte. Clamping one lane leaves the other lanes unaffected.
- R7: The right shift rounds toward minus infinity: input 0xFF gives 0xFF, and input 0x01 gives 0x00, in both modes.
- R8: A word accepted at a clock edge (in_valid and in_ready both high) appears on out_data with out_valid high right after that edge.
- R9: While out_valid is high and out_ready is low, in_ready is low, and out_valid and out_data hold their values.
- R10: The rate selection takes effect only after a cycle in which in_valid and out_valid are both low. A change of rate_sel while words are moving has no effect on those words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Code rate: 0 = 1/2, 1 = 1/3, 2 = 1/4, 3 = treated as 1/4 |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word |
| in_data | input | 32 | Four signed Q4 samples, lane 0 in bits 7:0 |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | 32 | Four requantized samples, sign-extended to 8 bits |

## Verification
The bench drives lanes that sit exactly on the 5-bit limits and one step beyond them:
- 0x1F next to 0x20, and 0xE0 next to 0xDF. A design that skipped the clamp would let 0x10 through where 0x0F belongs. A design with an off-by-one bound would clamp a legal value.
- Small negative values such as 0xFF. A logical shift, or a shift that rounds toward zero, would return 0x7F or 0x00 instead of 0xFF.
- Mixed lanes in one word. Swapped lanes, or a clamp signal shared across lanes, would corrupt the neighbours of a clamped lane.

Two timing cases are also covered:
- The rate is changed in the middle of a stalled, back-to-back stream. A design that latched the rate at any time would switch resolution mid-frame.
- A stall with out_ready low. Output data that did not hold would lose or overwrite a word.

// File: rtl/requant_pkg.sv
package requant_pkg;

  typedef enum logic [1:0] {
    RATE_HALF    = 2'd0,
    RATE_THIRD   = 2'd1,
    RATE_QUARTER = 2'd2,
    RATE_SPARE   = 2'd3
  } code_rate_e;

endpackage

// File: rtl/requant_mode.sv
module requant_mode #(
  parameter int RES_W      = 4,
  parameter int RES_WIDE   = 6,
  parameter int RES_NARROW = 5
) (
  input  logic                    clk,
  input  logic                    rst,
  input  requant_pkg::code_rate_e rate,
  input  logic                    idle,
  output logic [RES_W-1:0]        res_o
);
  import requant_pkg::*;

  logic [RES_W-1:0] res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= RES_W'(RES_WIDE);
    end else if (idle) begin
      res_q <= (rate == RATE_HALF) ? RES_W'(RES_WIDE) : RES_W'(RES_NARROW);
    end
  end

  assign res_o = res_q;

  // R2
  res_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (res_q == RES_W'(RES_WIDE)) || (res_q == RES_W'(RES_NARROW)));

endmodule

// File: rtl/requant_lane.sv
module requant_lane #(
  parameter int SAMPLE_W = 8,
  parameter int FRAC_W   = 4,
  parameter int RES_W    = 4
) (
  input  logic [SAMPLE_W-1:0] din,
  input  logic [RES_W-1:0]    res,
  output logic [SAMPLE_W-1:0] dout
);
  logic        [RES_W-1:0]    shamt;
  logic signed [SAMPLE_W-1:0] sin;
  logic signed [SAMPLE_W-1:0] shv;
  logic signed [SAMPLE_W-1:0] hi_lim;
  logic signed [SAMPLE_W-1:0] lo_lim;

  always_comb begin
    shamt  = res - RES_W'(FRAC_W);
    sin    = $signed(din);
    shv    = sin >>> shamt;
    hi_lim = SAMPLE_W'((1 << (res - RES_W'(1))) - 1);
    lo_lim = ~hi_lim;
    if (shv > hi_lim) begin
      dout = hi_lim;
    end else if (shv < lo_lim) begin
      dout = lo_lim;
    end else begin
      dout = shv;
    end
  end

endmodule

// File: rtl/requant_vit.sv
module requant_vit #(
  parameter int LANES      = 4,
  parameter int SAMPLE_W   = 8,
  parameter int FRAC_W     = 4,
  parameter int RES_WIDE   = 6,
  parameter int RES_NARROW = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                rate_sel,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANES*SAMPLE_W-1:0] in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LANES*SAMPLE_W-1:0] out_data
);
  import requant_pkg::*;

  localparam int RES_W  = $clog2(SAMPLE_W) + 1;
  localparam int WORD_W = LANES * SAMPLE_W;

  logic [RES_W-1:0]  res_q;
  logic [WORD_W-1:0] lane_out;
  logic              idle;
  logic              accept;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign idle     = !in_valid && !out_valid;

  requant_mode #(
    .RES_W(RES_W), .RES_WIDE(RES_WIDE), .RES_NARROW(RES_NARROW)
  ) u_mode (
    .clk(clk), .rst(rst), .rate(code_rate_e'(rate_sel)),
    .idle(idle), .res_o(res_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    requant_lane #(
      .SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W), .RES_W(RES_W)
    ) u_lane (
      .din (in_data[g*SAMPLE_W +: SAMPLE_W]),
      .res (res_q),
      .dout(lane_out[g*SAMPLE_W +: SAMPLE_W])
    );

    // R5
    lane_range_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |->
        ($signed(out_data[g*SAMPLE_W +: SAMPLE_W]) <=
           $signed(SAMPLE_W'((1 << (res_q - RES_W'(1))) - 1))) &&
        ($signed(out_data[g*SAMPLE_W +: SAMPLE_W]) >=
           $signed(~SAMPLE_W'((1 << (res_q - RES_W'(1))) - 1))));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= lane_out;
    end
  end

  // R8
  accept_to_out_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10
  res_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $stable(res_q));

endmodule

// File: tb/requant_vit_test.sv
module requant_vit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  rate_sel;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  requant_vit uut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [7:0] lane_model(logic [7:0] x, int d);
    int v;
    v = $signed(x);
    v = v >>> (d - 4);
    if (v > (1 << (d - 1)) - 1) v = (1 << (d - 1)) - 1;
    if (v < -(1 << (d - 1))) v = -(1 << (d - 1));
    return v[7:0];
  endfunction

  function automatic logic [31:0] word_model(logic [31:0] w, int d);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[k*8 +: 8] = lane_model(w[k*8 +: 8], d);
    return r;
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_rate(logic [1:0] r);
    rate_sel = r;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(logic [31:0] w, int d, string req);
    in_valid  = 1'b1;
    in_data   = w;
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check(req, out_data, word_model(w, d));
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1; rate_sel = 2'd0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_half;
    set_rate(2'd0);
    send(32'h10F07F80, 6, "R2 rate1/2 extremes");
    send(32'h7C83203F, 6, "R2 rate1/2 mixed");
    check("R2 sat-free 0x80", {24'd0, lane_model(8'h80, 6)}, 32'h000000E0);
  endtask

  task automatic t_third;
    set_rate(2'd1);
    send(32'h10F00A06, 5, "R3 rate1/3");
    set_rate(2'd2);
    send(32'hE11E0C13, 5, "R3 rate1/4");
    set_rate(2'd3);
    send(32'h7F804020, 5, "R4 spare code");
  endtask

  task automatic t_sat;
    set_rate(2'd1);
    send(32'hDFE0201F, 5, "R5 limits");
    check("R5 0x20 clamp", {24'd0, lane_model(8'h20, 5)}, 32'h0000000F);
    send(32'h80807F7F, 5, "R5 full scale");
  endtask

  task automatic t_lanes;
    set_rate(2'd1);
    send(32'h0402F07F, 5, "R6 lane0 clamp");
    send(32'h7F0402F0, 5, "R6 lane3 clamp");
  endtask

  task automatic t_floor;
    set_rate(2'd0);
    send(32'hFF01FEFD, 6, "R7 floor 6bit");
    set_rate(2'd1);
    send(32'hFF01FEFD, 5, "R7 floor 5bit");
  endtask

  task automatic t_stall;
    set_rate(2'd0);
    in_valid = 1'b1; in_data = 32'h11223344; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 valid after accept", {31'd0, out_valid}, 32'd1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 in_ready low", {31'd0, in_ready}, 32'd0);
      check("R9 data held", out_data, word_model(32'h11223344, 6));
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R9 drained", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_rate_hold;
    set_rate(2'd0);
    in_valid = 1'b1; in_data = 32'h40404040; out_ready = 1'b0;
    @(negedge clk);
    rate_sel = 2'd1;
    repeat (2) @(negedge clk);
    in_data = 32'h7F7F7F7F; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 no mid-stream switch", out_data, word_model(32'h7F7F7F7F, 6));
    @(negedge clk);
    @(negedge clk);
    send(32'h7F7F7F7F, 5, "R10 switch after idle");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_half();
    t_third();
    t_sat();
    t_lanes();
    t_floor();
    t_stall();
    t_rate_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule